// File: doc/BRIEF.md
# Immediate-Shift Operand Barrel Shifter

This block forms the second operand of a RISC-style datapath when an instruction asks for a register value shifted by a constant amount. It takes a 32-bit register value and a 12-bit operand field from the instruction. The field carries a 2-bit shift kind and a 5-bit constant amount. The block also takes the current carry flag. It returns the shifted value and a shifter carry-out. It is purely combinational, so the result is valid in the same cycle its inputs are.

A constant amount of zero cannot mean "no shift" for the right shifts and the rotate, so the block gives it a distinct meaning for each kind:
- logical left by zero passes the value through;
- logical right by zero and arithmetic right by zero become shifts by the full 32 bits;
- rotate by zero becomes a one-bit rotate through the carry flag.

A flag-update input selects what the carry-out shows. When it is high, the carry-out is the bit the shifter produced. When it is low, the carry-out is the incoming carry, unchanged.

The field is decoded into one of eight resolved operations, named `OP_PASS`, `OP_LSL`, `OP_LSR`, `OP_LSR_ALL`, `OP_ASR`, `OP_ASR_ALL`, `OP_ROR` and `OP_RRX`. Each operation has its own result path and its own carry path. There are no states or transitions: the resolved operation plays the role that a state plays in a sequential block.

Top module: `opshf_top`

## Requirements
- R1: The shift kind is read from operand bits [6:5], with 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. The amount n is read from bits [11:7]. Bits [4:0] have no effect on either output.
- R2: Logical left with n in 1..31 gives the value shifted left by n with zeros entering at the bottom, and a carry of input bit 32-n.
- R3: Logical left with n = 0 returns the value unchanged, and the carry equals the incoming carry flag.
- R4: Logical right with n in 1..31 gives the value shifted right by n with zeros entering at the top, and a carry of input bit n-1.
- R5: Logical right with n = 0 acts as a shift by 32: the result is all zeros and the carry is input bit 31.
- R6: Arithmetic right with n in 1..31 shifts right by n, filling with input bit 31, and gives a carry of input bit n-1.
- R7: Arithmetic right with n = 0 acts as a shift by 32: every result bit and the carry equal input bit 31.
- R8: Rotate right with n in 1..31 moves the low n bits to the top. The carry equals result bit 31.
- R9: Rotate right with n = 0 is a one-bit rotate through carry: the result is the input shifted right by one with the incoming carry in bit 31, and the carry is input bit 0.
- R10: When the flag-update input is low, the carry-out equals the incoming carry flag for every kind and amount. The result is the same as with the input high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_val | input | 32 | Register value to be shifted |
| i_opfield | input | 12 | Operand field: amount [11:7], kind [6:5], bits [4:0] unused |
| i_cin | input | 1 | Current carry flag |
| i_upd | input | 1 | High: carry-out shows the shifter carry; low: it shows i_cin |
| o_val | output | 32 | Shifted operand |
| o_cout | output | 1 | Shifter carry-out |

## Verification
The bench builds the block at its default 32-bit data width, so the amount field is exactly 5 bits wide. This makes every amount from 0 to 31 reachable for every kind, including the zero cases that are reinterpreted. Each kind and amount is driven with corner data (all zeros, all ones, single-bit patterns at both ends) and with random data, and with both carry-in values and both flag-update values. A separate pass scrambles operand bits [4:0] to show that they are ignored.

// File: rtl/opshf_pkg.sv
package opshf_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shkind_e;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_LSL,
        OP_LSR,
        OP_LSR_ALL,
        OP_ASR,
        OP_ASR_ALL,
        OP_ROR,
        OP_RRX
    } shop_e;

    localparam int KIND_LSB = 5;
    localparam int AMT_LSB  = 7;

endpackage

// File: rtl/opshf_decode.sv
module opshf_decode
    import opshf_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW+AMT_LSB-1:KIND_LSB] i_field,
    output shop_e                         o_op,
    output logic [AW-1:0]                 o_amt
);

    shkind_e kind;
    logic    amt_zero;

    always_comb begin
        kind     = shkind_e'(i_field[KIND_LSB+1:KIND_LSB]);
        o_amt    = i_field[AW+AMT_LSB-1:AMT_LSB];
        amt_zero = (o_amt == '0);
    end

    // Resolve kind and zero amount into one operation.
    always_comb begin
        unique case (kind)
            SK_LSL:  o_op = amt_zero ? OP_PASS    : OP_LSL;
            SK_LSR:  o_op = amt_zero ? OP_LSR_ALL : OP_LSR;
            SK_ASR:  o_op = amt_zero ? OP_ASR_ALL : OP_ASR;
            SK_ROR:  o_op = amt_zero ? OP_RRX     : OP_ROR;
            default: o_op = OP_PASS;
        endcase
    end

    // R5 R7 R9: a zero amount must never leave a plain shift operation.
    always_comb begin
        p_zero_amt_resolved_r9: assert (!(amt_zero &&
            (o_op == OP_LSR || o_op == OP_ASR || o_op == OP_ROR || o_op == OP_LSL)))
            else $error("zero amount decoded to plain shift");
    end

endmodule

// File: rtl/opshf_barrel.sv
module opshf_barrel #(
    parameter int W   = 33,
    parameter int SW  = 5,
    parameter bit ROT = 1'b0
) (
    input  logic [W-1:0]  i_din,
    input  logic [SW-1:0] i_amt,
    input  logic          i_fill,
    output logic [W-1:0]  o_dout
);

    logic [W-1:0] stg [SW+1];

    assign stg[0] = i_din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [W-1:0] moved;
        if (ROT) begin : g_rot
            assign moved = {stg[k][S-1:0], stg[k][W-1:S]};
        end else begin : g_shr
            assign moved = {{S{i_fill}}, stg[k][W-1:S]};
        end
        assign stg[k+1] = i_amt[k] ? moved : stg[k];
    end

    if (ROT) begin : g_fill_unused
        logic unused_fill;
        assign unused_fill = i_fill;
    end

    assign o_dout = stg[SW];

endmodule

// File: rtl/opshf_top.sv
module opshf_top
    import opshf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]              i_val,
    input  logic [$clog2(DW)+AMT_LSB-1:0] i_opfield,
    input  logic                       i_cin,
    input  logic                       i_upd,
    output logic [DW-1:0]              o_val,
    output logic                       o_cout
);

    localparam int AW = $clog2(DW);

    shop_e          op;
    logic [AW-1:0]  amt;
    logic           unused_low;

    assign unused_low = ^i_opfield[KIND_LSB-1:0];

    opshf_decode #(.AW(AW)) u_dec (
        .i_field (i_opfield[AW+AMT_LSB-1:KIND_LSB]),
        .o_op    (op),
        .o_amt   (amt)
    );

    // Shared shifter: left shifts run through it bit-reversed.
    // A guard bit below the data catches the last bit shifted out.
    logic [DW-1:0] val_rev, sh_rev;
    logic [DW:0]   sh_in, sh_out;
    logic          is_left, fill;

    for (genvar b = 0; b < DW; b++) begin : g_rev
        assign val_rev[b] = i_val[DW-1-b];
        assign sh_rev[b]  = sh_out[DW-b];
    end

    assign is_left = (op == OP_LSL);
    assign fill    = (op == OP_ASR) ? i_val[DW-1] : 1'b0;
    assign sh_in   = {is_left ? val_rev : i_val, 1'b0};

    opshf_barrel #(.W(DW+1), .SW(AW), .ROT(1'b0)) u_shr (
        .i_din  (sh_in),
        .i_amt  (amt),
        .i_fill (fill),
        .o_dout (sh_out)
    );

    logic [DW-1:0] rot_out;

    opshf_barrel #(.W(DW), .SW(AW), .ROT(1'b1)) u_rot (
        .i_din  (i_val),
        .i_amt  (amt),
        .i_fill (1'b0),
        .o_dout (rot_out)
    );

    // Output selection per resolved operation.
    logic cout_raw;

    always_comb begin
        unique case (op)
            OP_PASS: begin
                o_val    = i_val;
                cout_raw = i_cin;
            end
            OP_LSL: begin
                o_val    = sh_rev;
                cout_raw = sh_out[0];
            end
            OP_LSR, OP_ASR: begin
                o_val    = sh_out[DW:1];
                cout_raw = sh_out[0];
            end
            OP_LSR_ALL: begin
                o_val    = '0;
                cout_raw = i_val[DW-1];
            end
            OP_ASR_ALL: begin
                o_val    = {DW{i_val[DW-1]}};
                cout_raw = i_val[DW-1];
            end
            OP_ROR: begin
                o_val    = rot_out;
                cout_raw = rot_out[DW-1];
            end
            OP_RRX: begin
                o_val    = {i_cin, i_val[DW-1:1]};
                cout_raw = i_val[0];
            end
            default: begin
                o_val    = i_val;
                cout_raw = i_cin;
            end
        endcase
    end

    assign o_cout = i_upd ? cout_raw : i_cin;

    // Port-level checks across decoder, barrels and selection.
    always_comb begin
        p_hold_carry_r10: assert (i_upd || (o_cout == i_cin))
            else $error("carry not held with update low");
        p_pass_lsl0_r3: assert (!(i_opfield[AW+AMT_LSB-1:KIND_LSB] == '0) ||
                                 (o_val == i_val))
            else $error("lsl #0 changed value");
        p_lsr_all_r5: assert (!(op == OP_LSR_ALL) || (o_val == '0))
            else $error("lsr #32 result not zero");
        p_asr_all_r7: assert (!(op == OP_ASR_ALL) ||
                              (o_val == {DW{i_val[DW-1]}}))
            else $error("asr #32 result not sign");
        p_rrx_top_r9: assert (!(op == OP_RRX) || (o_val[DW-1] == i_cin))
            else $error("rrx top bit not carry");
        p_ror_carry_r8: assert (!(op == OP_ROR && i_upd) ||
                                (o_cout == o_val[DW-1]))
            else $error("ror carry not result msb");
    end

endmodule

// File: tb/sim_opshf_top.sv
module sim_opshf_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] val;
    logic [11:0] opf;
    logic        cin, upd;
    logic [31:0] dut_val;
    logic        dut_cout;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opshf_top u0 (
        .i_val     (val),
        .i_opfield (opf),
        .i_cin     (cin),
        .i_upd     (upd),
        .o_val     (dut_val),
        .o_cout    (dut_cout)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Behavioural reference written from the requirements.
    task automatic ref_model(input logic [31:0] v, input int kind, input int n,
                             input logic c, input logic u,
                             output logic [31:0] r, output logic co,
                             output string tag);
        logic [63:0] wide;
        case (kind)
            0: if (n == 0) begin r = v; co = c; tag = "R3"; end
               else begin r = v << n; co = v[32-n]; tag = "R2"; end
            1: if (n == 0) begin r = 32'd0; co = v[31]; tag = "R5"; end
               else begin r = v >> n; co = v[n-1]; tag = "R4"; end
            2: if (n == 0) begin r = v[31] ? 32'hFFFF_FFFF : 32'd0; co = v[31]; tag = "R7"; end
               else begin r = 32'($signed(v) >>> n); co = v[n-1]; tag = "R6"; end
            default:
               if (n == 0) begin r = (v >> 1) | (32'(c) << 31); co = v[0]; tag = "R9"; end
               else begin
                   wide = {v, v} >> n;
                   r = wide[31:0]; co = r[31]; tag = "R8";
               end
        endcase
        if (!u) begin co = c; tag = {tag, "/R10"}; end
    endtask

    task automatic apply_check(input logic [31:0] v, input int kind, input int n,
                               input logic [4:0] low, input logic c, input logic u);
        logic [31:0] er;
        logic ec;
        string tag;
        @(negedge clk);
        val = v;
        opf = {5'(n), 2'(kind), low};
        cin = c;
        upd = u;
        ref_model(v, kind, n, c, u, er, ec, tag);
        @(posedge clk);
        #1;
        checks++;
        if (dut_val !== er || dut_cout !== ec) begin
            errors++;
            $display("FAIL %s kind=%0d n=%0d v=%h cin=%b upd=%b: got %h/%b exp %h/%b",
                     tag, kind, n, v, c, u, dut_val, dut_cout, er, ec);
        end
    endtask

    logic [31:0] pats [8];

    initial begin
        val = '0; opf = '0; cin = 1'b0; upd = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Initial state with all inputs low (R3: pass, carry held).
        #1;
        checks++;
        if (dut_val !== 32'd0 || dut_cout !== 1'b0) begin
            errors++;
            $display("FAIL R3 idle: got %h/%b exp 00000000/0", dut_val, dut_cout);
        end

        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0001;
        pats[3] = 32'h7FFF_FFFE;
        pats[4] = 32'hA5C3_0F96;
        for (int i = 5; i < 8; i++) pats[i] = $urandom;

        // R2..R10 sweep: every kind, every amount, corner and random data.
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 32; n++)
                for (int p = 0; p < 8; p++)
                    for (int cu = 0; cu < 4; cu++)
                        apply_check(pats[p], k, n, 5'd0, cu[0], cu[1]);

        // R1: bits [4:0] scrambled have no effect on either output.
        for (int t = 0; t < 200; t++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply_check(rv, t % 4, (t * 7) % 32, 5'($urandom), t[1], t[2]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule